// File: doc/BRIEF.md
# Banked Interrupt Aggregation Controller

This block collects up to 160 level-type interrupt sources, grouped into five banks of 32 bit positions, and reduces them to two request lines for a processor. Each bank has an enable register and a status register. The status register latches every implemented source that is high at a clock edge, whether or not it is enabled. A source is pending when both its status bit and its enable bit are 1. Banks 0 to 2 carry functional sources and drive `irq_func`. Banks 3 and 4 carry error sources and drive `irq_err`.

Sources are identified by bit position, not by a running count: identifier = 32 × bank + bit. Banks are only partly populated (32, 32, 24, 32 and 17 implemented bits), and the gaps are kept, so bit 0 of bank 3 is source 96. Software reads one register to get the highest-priority pending identifier. Priority runs from bank 0 to bank 4 and, within a bank, from bit 0 upward, which is the same as the lowest identifier first. Software then acknowledges that source by writing a single 1 to its status bit.

The register port is a plain single-cycle write strobe and a separately addressed read strobe. Reads return data one cycle later. No back-pressure is applied, so every strobe is accepted in the cycle it is presented.

Top module: `irqagg_top`

## Requirements
- R1: After reset every enable and status register reads 0, both request outputs are low, and the next-pending register reads 0.
- R2: An implemented source that is high at a rising clock edge sets its status bit at that edge, whether or not it is enabled. The bit stays set after the source falls.
- R3: Bank widths are 32, 32, 24, 32 and 17 bits. Bits above a bank's width read 0 in both its enable and status registers and can never be set.
- R4: Writing the status register of bank b (address 8+b) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R5: If a source is high in the same cycle as a write that clears its status bit, the bit remains set.
- R6: Writing address b (b = 0..4) loads the enable register of bank b with the written data, masked to the implemented bits. Reads of that address return the stored value.
- R7: `irq_func` is high exactly when some bit is set in both status and enable in bank 0, 1 or 2. It follows register changes in the cycle after the edge that makes them.
- R8: `irq_err` is high exactly when some bit is set in both status and enable in bank 3 or 4, with the same timing as R7.
- R9: Address 15 reads the next-pending register. Bit 31 is a valid flag, and bits 7:0 hold the lowest pending identifier (32 × bank + bit). The whole word is 0 when nothing is pending.
- R10: A read strobe at one edge presents the addressed value on `rd_data` after that edge and holds it until the next read. Addresses 5, 6, 7, 13 and 14 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 160 | Source levels, bit 32×bank+bit |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address (0..4 enable, 8..12 status) |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Read address (0..4 enable, 8..12 status, 15 next pending) |
| rd_data | output | 32 | Registered read data |
| irq_func | output | 1 | Functional group request |
| irq_err | output | 1 | Error group request |

## Verification
A source level or a register write presented before edge k changes the status or enable registers at edge k. Both request outputs and the next-pending value reflect that change in the cycle after edge k. A read strobed at edge k returns the register contents as they stood before edge k, and `rd_data` holds that value after the edge. The bench drives all inputs at the falling edge. It advances its reference model at the rising edge, computing the expected read data from the model state before the update. It then compares the request lines and `rd_data` at the next falling edge, so every comparison falls in the cycle where the result is due.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int unsigned BANK_W     = 32;
  localparam int unsigned NUM_BANKS  = 5;
  localparam int unsigned FUNC_BANKS = 3;
  localparam int unsigned ADDR_W     = 4;

  // number of implemented bits in each bank
  function automatic int unsigned bank_bits(int unsigned b);
    case (b)
      0, 1, 3: return 32;
      2:       return 24;
      4:       return 17;
      default: return 0;
    endcase
  endfunction

  function automatic logic [BANK_W-1:0] bank_mask(int unsigned b);
    logic [BANK_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < BANK_W; i++)
      if (i < bank_bits(b)) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irqagg_bank.sv
module irqagg_bank
  import irqagg_pkg::*;
#(
  parameter int unsigned BANK_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] src,
  input  logic              en_we,
  input  logic              sts_we,
  input  logic [BANK_W-1:0] wdata,
  output logic [BANK_W-1:0] en_q,
  output logic [BANK_W-1:0] sts_q,
  output logic [BANK_W-1:0] pend
);
  localparam logic [BANK_W-1:0] IMPL = bank_mask(BANK_IDX);

  logic [BANK_W-1:0] clr;
  logic [BANK_W-1:0] sts_d;

  always_comb begin
    clr   = sts_we ? wdata : '0;
    // a new event overrides a simultaneous acknowledge
    sts_d = ((sts_q & ~clr) | src) & IMPL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      sts_q <= '0;
    end else begin
      sts_q <= sts_d;
      if (en_we) en_q <= wdata & IMPL;
    end
  end

  assign pend = sts_q & en_q;
endmodule

// File: rtl/irqagg_prio.sv
module irqagg_prio #(
  parameter int unsigned N   = 160,
  parameter int unsigned IDW = $clog2(N)
) (
  input  logic [N-1:0]   pend,
  output logic           valid,
  output logic [IDW-1:0] id
);
  // lowest index wins: bank order first, then bit order
  always_comb begin
    valid = 1'b0;
    id    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        valid = 1'b1;
        id    = IDW'(i);
      end
    end
  end
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
  import irqagg_pkg::*;
#(
  parameter int unsigned NUM_SRC = NUM_BANKS * BANK_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [BANK_W-1:0]  wr_data,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [BANK_W-1:0]  rd_data,
  output logic               irq_func,
  output logic               irq_err
);
  localparam int unsigned IDW       = $clog2(NUM_SRC);
  localparam int unsigned STS_BASE  = 1 << (ADDR_W - 1);
  localparam logic [ADDR_W-1:0] NEXT_ADDR = '1;
  localparam int unsigned FUNC_BITS = FUNC_BANKS * BANK_W;

  logic [NUM_SRC-1:0] en_flat;
  logic [NUM_SRC-1:0] sts_flat;
  logic [NUM_SRC-1:0] pend_flat;
  logic               nxt_valid;
  logic [IDW-1:0]     nxt_id;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [ADDR_W-1:0] EN_A  = ADDR_W'(b);
    localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(STS_BASE + b);

    irqagg_bank #(.BANK_IDX(b)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .src    (src_in[b*BANK_W +: BANK_W]),
      .en_we  (wr_en && (wr_addr == EN_A)),
      .sts_we (wr_en && (wr_addr == STS_A)),
      .wdata  (wr_data),
      .en_q   (en_flat[b*BANK_W +: BANK_W]),
      .sts_q  (sts_flat[b*BANK_W +: BANK_W]),
      .pend   (pend_flat[b*BANK_W +: BANK_W])
    );
  end

  irqagg_prio #(.N(NUM_SRC), .IDW(IDW)) u_prio (
    .pend  (pend_flat),
    .valid (nxt_valid),
    .id    (nxt_id)
  );

  assign irq_func = |pend_flat[FUNC_BITS-1:0];
  assign irq_err  = |pend_flat[NUM_SRC-1:FUNC_BITS];

  logic [BANK_W-1:0] rd_val;

  always_comb begin
    rd_val = '0;
    for (int unsigned b = 0; b < NUM_BANKS; b++) begin
      if (rd_addr == ADDR_W'(b))
        rd_val = en_flat[b*BANK_W +: BANK_W];
      if (rd_addr == ADDR_W'(STS_BASE + b))
        rd_val = sts_flat[b*BANK_W +: BANK_W];
    end
    if (rd_addr == NEXT_ADDR) begin
      rd_val[BANK_W-1] = nxt_valid;
      rd_val[IDW-1:0]  = nxt_id;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_val;
  end
endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker
  import irqagg_pkg::*;
#(
  parameter int unsigned NUM_SRC = NUM_BANKS * BANK_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_in,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [BANK_W-1:0]  wr_data,
  input logic [NUM_SRC-1:0] en_flat,
  input logic [NUM_SRC-1:0] sts_flat,
  input logic               irq_func,
  input logic               irq_err
);
  localparam int unsigned FUNC_BITS = FUNC_BANKS * BANK_W;
  localparam int unsigned STS_BASE  = 1 << (ADDR_W - 1);

  logic [NUM_SRC-1:0] impl;
  logic [NUM_SRC-1:0] clr_flat;
  logic               en_write;

  always_comb begin
    impl     = '0;
    clr_flat = '0;
    en_write = 1'b0;
    for (int unsigned b = 0; b < NUM_BANKS; b++) begin
      impl[b*BANK_W +: BANK_W] = bank_mask(b);
      if (wr_en && wr_addr == ADDR_W'(STS_BASE + b))
        clr_flat[b*BANK_W +: BANK_W] = wr_data;
      if (wr_en && wr_addr == ADDR_W'(b))
        en_write = 1'b1;
    end
  end

  assert_event_latched_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((sts_flat & $past(src_in & impl)) == $past(src_in & impl)));

  assert_unimpl_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_flat | en_flat) & ~impl) == '0);

  assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((sts_flat & $past(clr_flat & ~src_in)) == '0));

  assert_enable_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_write |=> $stable(en_flat));

  assert_func_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_func == (|(sts_flat[FUNC_BITS-1:0] & en_flat[FUNC_BITS-1:0])));

  assert_err_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err == (|(sts_flat[NUM_SRC-1:FUNC_BITS] & en_flat[NUM_SRC-1:FUNC_BITS])));
endmodule

bind irqagg_top irqagg_checker #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .src_in   (src_in),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .en_flat  (en_flat),
  .sts_flat (sts_flat),
  .irq_func (irq_func),
  .irq_err  (irq_err)
);

// File: tb/irqagg_top_bench.sv
`timescale 1ns/1ps
module irqagg_top_bench;
  localparam int NB = 5;
  localparam int NS = 160;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS-1:0] src_in;
  logic          wr_en, rd_en;
  logic [3:0]    wr_addr, rd_addr;
  logic [31:0]   wr_data;
  logic [31:0]   rd_data;
  logic          irq_func, irq_err;

  always #2 clk = ~clk;

  irqagg_top u_irqagg_top (
    .clk(clk), .rst_n(rst_n), .src_in(src_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_func(irq_func), .irq_err(irq_err)
  );

  int n_checks = 0;
  int n_err    = 0;
  bit finished = 0;
  logic [31:0] m_en [NB];
  logic [31:0] m_st [NB];

  function automatic logic [31:0] bmask(int b);
    case (b)
      2:       return 32'h00FF_FFFF;
      4:       return 32'h0001_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] mnext();
    for (int b = 0; b < NB; b++)
      for (int i = 0; i < 32; i++)
        if (m_st[b][i] && m_en[b][i]) return 32'h8000_0000 | 32'(32*b + i);
    return 32'h0;
  endfunction

  function automatic logic [31:0] mread(logic [3:0] a);
    if (a < 4'd5)  return m_en[a];
    if (a >= 4'd8 && a < 4'd13) return m_st[a - 4'd8];
    if (a == 4'd15) return mnext();
    return 32'h0;
  endfunction

  function automatic logic exp_func();
    logic r = 1'b0;
    for (int b = 0; b < 3; b++) r |= |(m_st[b] & m_en[b]);
    return r;
  endfunction

  function automatic logic exp_err();
    logic r = 1'b0;
    for (int b = 3; b < NB; b++) r |= |(m_st[b] & m_en[b]);
    return r;
  endfunction

  function automatic logic [NS-1:0] one(int id);
    return NS'(1) << id;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int b = 0; b < NB; b++) begin
      m_en[b] = '0;
      m_st[b] = '0;
    end
  endtask

  // one clock cycle: inputs driven now (falling edge), results checked at next falling edge
  task automatic cyc(logic [NS-1:0] s, bit we, logic [3:0] wa, logic [31:0] wd,
                     bit re, logic [3:0] ra, string req);
    logic [31:0] exp_rd;
    src_in = s; wr_en = we; wr_addr = wa; wr_data = wd;
    rd_en = re; rd_addr = ra;
    @(posedge clk);
    exp_rd = mread(ra);
    for (int b = 0; b < NB; b++) begin
      if (we && wa == 4'(8 + b)) m_st[b] &= ~wd;
      m_st[b] = (m_st[b] | s[32*b +: 32]) & bmask(b);
      if (we && wa == 4'(b)) m_en[b] = wd & bmask(b);
    end
    @(negedge clk);
    check("R7 irq_func", 32'(irq_func), 32'(exp_func()));
    check("R8 irq_err", 32'(irq_err), 32'(exp_err()));
    if (re) check(req, rd_data, exp_rd);
    src_in = '0; wr_en = 0; rd_en = 0;
  endtask

  task automatic rd(logic [3:0] a, string req);
    cyc('0, 0, 4'd0, 32'd0, 1, a, req);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    cyc('0, 1, a, d, 0, 4'd0, "");
  endtask

  function automatic logic [31:0] rnd_word();
    return $urandom & $urandom & $urandom & $urandom;
  endfunction

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_checks++; n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 0; src_in = '0; wr_en = 0; rd_en = 0;
    wr_addr = '0; rd_addr = '0; wr_data = '0;
    model_reset();
    repeat (3) @(negedge clk);
    check("R1 irq_func", 32'(irq_func), 32'h0);
    check("R1 irq_err", 32'(irq_err), 32'h0);
    rst_n = 1;
    @(negedge clk);
    for (int a = 0; a < 16; a++) rd(4'(a), "R1 reset read");

    // enable register width and masking
    wr(4'd0, 32'hFFFF_FFFF); rd(4'd0, "R6 enable readback");
    wr(4'd2, 32'hFFFF_FFFF); rd(4'd2, "R3 bank2 enable mask");
    wr(4'd4, 32'hFFFF_FFFF); rd(4'd4, "R3 bank4 enable mask");
    check("R3 bank4 literal", m_en[4], 32'h0001_FFFF);

    // disabled source latches, no request
    cyc(one(37), 0, 4'd0, 32'd0, 0, 4'd0, "");
    rd(4'd9, "R2 status latched");
    check("R2 held after source drop", m_st[1], 32'h0000_0020);
    check("R7 disabled source quiet", 32'(irq_func), 32'h0);
    rd(4'd15, "R9 nothing pending");
    wr(4'd1, 32'h0000_0020);
    rd(4'd15, "R9 next is 37");
    check("R7 enabled source raises", 32'(irq_func), 32'h1);

    // lower identifier takes priority
    cyc(one(80), 0, 4'd0, 32'd0, 0, 4'd0, "");
    rd(4'd15, "R9 still 37");
    cyc(one(3), 0, 4'd0, 32'd0, 0, 4'd0, "");
    rd(4'd15, "R9 next is 3");

    // write-1-to-clear
    wr(4'd9, 32'h0); rd(4'd9, "R4 zero write keeps");
    wr(4'd9, 32'h20); rd(4'd9, "R4 one write clears");

    // event beats same-cycle clear
    cyc(one(3), 1, 4'd8, 32'h8, 0, 4'd0, "");
    rd(4'd8, "R5 event wins");
    check("R5 bit3 set", m_st[0] & 32'h8, 32'h8);
    wr(4'd8, 32'hFFFF_FFFF);
    wr(4'd10, 32'hFFFF_FFFF);
    rd(4'd15, "R9 empty after clears");

    // error group
    cyc(one(96), 0, 4'd0, 32'd0, 0, 4'd0, "");
    wr(4'd3, 32'h1);
    check("R8 error raised", 32'(irq_err), 32'h1);
    check("R7 functional quiet", 32'(irq_func), 32'h0);
    rd(4'd15, "R9 next is 96");

    // unimplemented bits
    cyc(one(90) | one(150), 0, 4'd0, 32'd0, 0, 4'd0, "");
    rd(4'd10, "R3 bank2 bit26 absent");
    rd(4'd12, "R3 bank4 bit22 absent");

    // unmapped addresses
    wr(4'd5, 32'hFFFF_FFFF); wr(4'd13, 32'hFFFF_FFFF); wr(4'd7, 32'hFFFF_FFFF);
    rd(4'd5, "R10 unmapped reads zero");
    rd(4'd13, "R10 unmapped status reads zero");
    rd(4'd0, "R10 enable0 untouched");
    rd(4'd11, "R10 status3 untouched");
    check("R10 read data held", rd_data, 32'h0000_0001);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [NS-1:0] s;
      logic [3:0] wa, ra;
      logic [31:0] wd;
      s = '0;
      if ($urandom_range(3) == 0)
        for (int b = 0; b < NB; b++) s[32*b +: 32] = rnd_word();
      wa = 4'($urandom_range(15));
      ra = 4'($urandom_range(15));
      wd = (wa < 4'd5) ? $urandom : ($urandom | rnd_word());
      cyc(s, $urandom_range(2) == 0, wa, wd, $urandom_range(1) == 0, ra,
          "R6 R9 random read");
    end

    // reset in mid-run clears everything
    @(negedge clk);
    rst_n = 0;
    model_reset();
    @(negedge clk);
    check("R1 func low in reset", 32'(irq_func), 32'h0);
    rst_n = 1;
    @(negedge clk);
    for (int a = 0; a < 16; a++) rd(4'(a), "R1 reread after reset");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule